// File: doc/BRIEF.md
# PCM Pair Serializer

This block turns four parallel conversion words into two stereo serial streams. Channels 1 and 2 share serial output `sdo_a`; channels 3 and 4 share `sdo_b`. Each frame has a left half, while the frame clock is low, and a right half, while it is high. Words go out MSB first, and the MSB sits one bit clock after each frame-clock edge. Sample words are 32-bit two's-complement values, left-aligned: the effective word is the top 16, 24 or 32 bits.

The bit and frame clocks can come from outside, in slave mode. They can also be generated from the system clock, in master mode, at a fixed 64 bit clocks per frame. All edges are handled as sampled levels in the `clk` domain.

The block counts bit clocks per frame. From that count it decides whether the ratio is legal for the selected speed class, and in the fastest class it picks the word length. An illegal ratio raises an error flag and mutes both outputs.

The format controls are taken in only while `chan_rst` is high. These controls are the mode, the speed class, the word select and the rate flag.

Top module: `pcm_pair_serializer`

## Requirements
- R1: While the frame clock is low, `sdo_a` carries `smp_ch1` and `sdo_b` carries `smp_ch3`. While it is high, they carry `smp_ch2` and `smp_ch4`.
- R2: With word length W and N bit clocks per half frame, counting bit-clock falling edges k from the frame-clock edge (k=0):
  - slot k (1 ≤ k ≤ W) carries input bit 32-k, so the MSB comes first;
  - slots after the LSB are low;
  - when N equals W, the LSB lands in the k=0 slot of the next half.
- R3: In master mode (`master_en`=1), `bick_out` toggles every BCK_HALF clock cycles. `lrck_out` toggles only together with a falling edge of `bick_out`, every 32 falling edges, which gives 64 bit clocks per frame.
- R4: Data changes on the bit-clock falling edge in master mode, and in slave mode when `rate_extreme`=0. In slave mode with `rate_extreme`=1, each bit is launched on the rising edge before that falling edge.
- R5: For speed codes 00, 01 and 10 (normal, double, quad), any ratio from 48 to 128 bit clocks per frame is legal. `wsel`=0 selects 24-bit words and `wsel`=1 selects 32-bit words.
- R6: For speed code 11 (oct), only ratios of 32, 48 and 64 are legal. 32 forces 16-bit words and 48 forces 24-bit words whatever `wsel` is. At 64, `wsel` chooses between 24 and 32 bits.
- R7: After a frame with an illegal ratio, `ratio_err` is high and both outputs stay low. The measurement is renewed at every frame-clock falling edge.
- R8: The mode, speed, word-select and rate inputs take effect only while `chan_rst` is high. Changing them while `chan_rst` is low has no effect.
- R9: While `chan_rst` is high, `sdo_a`, `sdo_b`, `ratio_err`, `bick_out` and `lrck_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Channel hold; format inputs are captured while high |
| master_en | input | 1 | 1 = generate bit and frame clocks, 0 = follow external ones |
| rate_extreme | input | 1 | 1 = sample rate outside the normal 8 to 216 kHz window |
| speed | input | 2 | Speed class: 00 normal, 01 double, 10 quad, 11 oct |
| wsel | input | 1 | Word-length select: 0 = 24 bit, 1 = 32 bit |
| bick_in | input | 1 | External bit clock (slave) |
| lrck_in | input | 1 | External frame clock (slave) |
| smp_ch1 | input | 32 | Channel 1 word |
| smp_ch2 | input | 32 | Channel 2 word |
| smp_ch3 | input | 32 | Channel 3 word |
| smp_ch4 | input | 32 | Channel 4 word |
| bick_out | output | 1 | Generated bit clock (master) |
| lrck_out | output | 1 | Generated frame clock (master) |
| sdo_a | output | 1 | Serial data, channels 1 and 2 |
| sdo_b | output | 1 | Serial data, channels 3 and 4 |
| ratio_err | output | 1 | Measured bit-clock ratio not legal |

## Verification
A wrong frame counter or word-length decision shows up within two frames. It appears either as a flipped `ratio_err` or as bits that are missing or extra after the LSB, most visibly in the slot that shares the frame-clock edge. A wrong shift register or channel select corrupts the very next half frame on one output. A wrong launch-edge choice moves every transition by half a bit clock, so sampling the outputs just before each falling edge exposes it on the first bit.

// File: rtl/pcm_pair_serializer.sv
module pcm_pair_serializer #(
  parameter int BCK_HALF = 2,
  parameter int M_SLOTS  = 32,
  parameter int CNT_W    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chan_rst,
  input  logic        master_en,
  input  logic        rate_extreme,
  input  logic [1:0]  speed,
  input  logic        wsel,
  input  logic        bick_in,
  input  logic        lrck_in,
  input  logic [31:0] smp_ch1,
  input  logic [31:0] smp_ch2,
  input  logic [31:0] smp_ch3,
  input  logic [31:0] smp_ch4,
  output logic        bick_out,
  output logic        lrck_out,
  output logic        sdo_a,
  output logic        sdo_b,
  output logic        ratio_err
);
  localparam int DW  = $clog2(BCK_HALF) + 1;
  localparam int SLW = $clog2(M_SLOTS) + 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic cfg_m, cfg_x, cfg_w;
  logic [1:0] cfg_sp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_m <= 1'b0; cfg_x <= 1'b0; cfg_w <= 1'b0; cfg_sp <= 2'b00;
    end else if (chan_rst) begin
      cfg_m <= master_en; cfg_x <= rate_extreme; cfg_w <= wsel; cfg_sp <= speed;
    end

  logic [DW-1:0]  mdiv;
  logic [SLW-1:0] mslot;
  logic mb, ml;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mdiv <= '0; mslot <= '0; mb <= 1'b0; ml <= 1'b0;
    end else if (chan_rst || !cfg_m) begin
      mdiv <= '0; mslot <= '0; mb <= 1'b0; ml <= 1'b0;
    end else if (mdiv == DW'(BCK_HALF - 1)) begin
      mdiv <= '0;
      mb   <= ~mb;
      if (mb) begin
        if (mslot == SLW'(M_SLOTS - 1)) begin
          mslot <= '0;
          ml    <= ~ml;
        end else
          mslot <= mslot + 1'b1;
      end
    end else
      mdiv <= mdiv + 1'b1;

  assign bick_out = mb;
  assign lrck_out = ml;

  logic bk, lk, bq, lf;
  logic fall, rise, lr_chg, fstart;

  assign bk = cfg_m ? mb : bick_in;
  assign lk = cfg_m ? ml : lrck_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bq <= 1'b0; lf <= 1'b0;
    end else begin
      bq <= bk;
      if (chan_rst) lf <= 1'b0;
      else if (fall) lf <= lk;
    end

  assign fall   = bq & ~bk;
  assign rise   = ~bq & bk;
  assign lr_chg = fall & (lk != lf);
  assign fstart = lr_chg & ~lk;

  logic [CNT_W-1:0] cnt;
  logic seen, ok, err;
  logic [5:0] wl, wl_nx;
  logic oct, legal;

  assign oct   = (cfg_sp == 2'b11);
  assign legal = oct ? (cnt == CNT_W'(32) || cnt == CNT_W'(48) || cnt == CNT_W'(64))
                     : (cnt >= CNT_W'(48) && cnt <= CNT_W'(128));

  always_comb begin
    wl_nx = cfg_w ? 6'd32 : 6'd24;
    if (oct && cnt == CNT_W'(32)) wl_nx = 6'd16;
    if (oct && cnt == CNT_W'(48)) wl_nx = 6'd24;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; seen <= 1'b0; ok <= 1'b0; err <= 1'b0; wl <= 6'd24;
    end else if (chan_rst) begin
      cnt <= '0; seen <= 1'b0; ok <= 1'b0; err <= 1'b0; wl <= 6'd24;
    end else if (fstart) begin
      cnt  <= '0;
      seen <= 1'b1;
      if (seen) begin
        ok  <= legal;
        err <= ~legal;
        wl  <= wl_nx;
      end
    end else if (rise && cnt != CMAX)
      cnt <= cnt + 1'b1;

  assign ratio_err = err;

  logic [31:0] mask, wa, wb, sh_a, sh_b;
  logic sd_a, sd_b, rmode, launch;

  assign mask   = ~(32'hFFFF_FFFF >> wl);
  assign wa     = (lk ? smp_ch2 : smp_ch1) & mask;
  assign wb     = (lk ? smp_ch4 : smp_ch3) & mask;
  assign rmode  = ~cfg_m & cfg_x;
  assign launch = rmode ? rise : fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_a <= '0; sh_b <= '0; sd_a <= 1'b0; sd_b <= 1'b0;
    end else if (chan_rst) begin
      sh_a <= '0; sh_b <= '0; sd_a <= 1'b0; sd_b <= 1'b0;
    end else begin
      if (fall) begin
        if (lr_chg) begin
          sh_a <= ok ? wa : '0;
          sh_b <= ok ? wb : '0;
        end else begin
          sh_a <= {sh_a[30:0], 1'b0};
          sh_b <= {sh_b[30:0], 1'b0};
        end
      end
      if (launch) begin
        sd_a <= sh_a[31] & ok;
        sd_b <= sh_b[31] & ok;
      end
    end

  assign sdo_a = sd_a;
  assign sdo_b = sd_b;
endmodule

// File: rtl/pcm_pair_serializer_chk.sv
module pcm_pair_serializer_chk #(
  parameter int BCK_HALF = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_rst,
  input logic       bick_out,
  input logic       lrck_out,
  input logic       sdo_a,
  input logic       sdo_b,
  input logic       ratio_err,
  input logic       bk,
  input logic       rmode,
  input logic       cfg_m,
  input logic       cfg_x,
  input logic       cfg_w,
  input logic [1:0] cfg_sp
);
  assert_quiet_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (!sdo_a && !sdo_b && !ratio_err && !bick_out && !lrck_out));

  assert_err_mutes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdo_a) || $rose(sdo_b)) |-> !$past(ratio_err));

  assert_bick_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (BCK_HALF > 1 && !$past(chan_rst) && !chan_rst && bick_out != $past(bick_out))
      |=> $stable(bick_out));

  assert_lrck_on_bick_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(chan_rst) && lrck_out != $past(lrck_out)) |-> (!bick_out && $past(bick_out)));

  assert_launch_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(chan_rst) && (sdo_a != $past(sdo_a) || sdo_b != $past(sdo_b)))
      |-> ($past(rmode) ? ($past(bk) && !$past(bk, 2)) : (!$past(bk) && $past(bk, 2))));

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_rst |=> $stable({cfg_m, cfg_x, cfg_w, cfg_sp}));
endmodule

bind pcm_pair_serializer pcm_pair_serializer_chk #(.BCK_HALF(BCK_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
  .bick_out(bick_out), .lrck_out(lrck_out),
  .sdo_a(sdo_a), .sdo_b(sdo_b), .ratio_err(ratio_err),
  .bk(bk), .rmode(rmode),
  .cfg_m(cfg_m), .cfg_x(cfg_x), .cfg_w(cfg_w), .cfg_sp(cfg_sp)
);

// File: tb/tb_pcm_pair_serializer.sv
module tb_pcm_pair_serializer;
  localparam int BCK_HALF = 2;
  localparam int HB = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, chan_rst, master_en, rate_extreme, wsel, bick_d, lrck_d;
  logic [1:0] speed;
  logic [31:0] s1, s2, s3, s4;
  logic bick_out, lrck_out, sdo_a, sdo_b, ratio_err;

  pcm_pair_serializer #(.BCK_HALF(BCK_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .master_en(master_en),
    .rate_extreme(rate_extreme), .speed(speed), .wsel(wsel),
    .bick_in(bick_d), .lrck_in(lrck_d),
    .smp_ch1(s1), .smp_ch2(s2), .smp_ch3(s3), .smp_ch4(s4),
    .bick_out(bick_out), .lrck_out(lrck_out), .sdo_a(sdo_a), .sdo_b(sdo_b),
    .ratio_err(ratio_err)
  );

  int total = 0, bad = 0;
  int e_nh, e_w;
  logic e_ok, e_rise;
  logic chk_en = 1'b0;
  int bit_n, bit_bad, pre_n, pre_bad;
  int rcnt = 0, mon_ratio = 0, clkcnt = 0, last_rise = 0, mon_per = 0, k_m = 0;
  logic pb = 1'b0, plf = 1'b0, half_m = 1'b0;
  logic [1:0] lastb = 2'b00;

  function automatic logic [1:0] exp_pair(input logic h, input int k);
    logic [31:0] ca, pa, cb, pbw;
    logic ea, eb;
    ca = h ? s2 : s1; pa = h ? s1 : s2;
    cb = h ? s4 : s3; pbw = h ? s3 : s4;
    if (!e_ok) return 2'b00;
    if (k == 0) begin
      ea = (e_nh == e_w) ? pa[32-e_w] : 1'b0;
      eb = (e_nh == e_w) ? pbw[32-e_w] : 1'b0;
    end else if (k <= e_w) begin
      ea = ca[32-k]; eb = cb[32-k];
    end else begin
      ea = 1'b0; eb = 1'b0;
    end
    return {ea, eb};
  endfunction

  initial forever begin
    logic mb, ml;
    logic [1:0] e;
    @(negedge clk); #1;
    clkcnt++;
    mb = master_en ? bick_out : bick_d;
    ml = master_en ? lrck_out : lrck_d;
    if (pb && !mb) begin
      if (ml != plf) begin
        k_m = 0; half_m = ml; plf = ml;
        if (!ml) begin mon_ratio = rcnt; rcnt = 0; end
      end else k_m++;
      e = exp_pair(half_m, k_m);
      if (chk_en) begin
        pre_n++;
        if ({sdo_a, sdo_b} != (e_rise ? e : lastb)) pre_bad++;
      end
      lastb = e;
    end
    if (!pb && mb) begin
      rcnt++;
      mon_per = clkcnt - last_rise;
      last_rise = clkcnt;
      if (chk_en) begin
        bit_n++;
        if ({sdo_a, sdo_b} != lastb) bit_bad++;
      end
    end
    pb = mb;
  end

  task automatic chk(input logic cond, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic slave_frames(input int nh, input int nf);
    for (int f = 0; f < nf; f++)
      for (int h = 0; h < 2; h++)
        for (int k = 0; k < nh; k++) begin
          @(negedge clk);
          bick_d = 1'b0;
          if (k == 0) lrck_d = h[0];
          repeat (HB - 1) @(negedge clk);
          @(negedge clk);
          bick_d = 1'b1;
          repeat (HB - 1) @(negedge clk);
        end
  endtask

  task automatic run_cfg(input logic m, input logic rx, input logic [1:0] sp,
                         input logic dw, input int nh, input int w, input logic okv,
                         input logic late, input string tag);
    @(negedge clk);
    chan_rst = 1'b1; chk_en = 1'b0;
    master_en = m; rate_extreme = rx; speed = sp; wsel = dw;
    s1 = $urandom; s2 = $urandom; s3 = $urandom; s4 = $urandom;
    e_nh = m ? 32 : nh; e_w = w; e_ok = okv; e_rise = !m && rx;
    repeat (4) @(negedge clk);
    chan_rst = 1'b0;
    bit_n = 0; bit_bad = 0; pre_n = 0; pre_bad = 0;
    if (m) begin
      repeat (900) @(negedge clk);
      chk_en = 1'b1;
      repeat (520) @(negedge clk);
      chk_en = 1'b0;
    end else begin
      slave_frames(nh, 4);
      if (late) begin speed = 2'b00; wsel = ~wsel; master_en = 1'b0; end
      chk_en = 1'b1;
      slave_frames(nh, 2);
      chk_en = 1'b0;
    end
    chk(bit_bad == 0 && bit_n > 0, tag, "bit mismatches", bit_bad, 0);
    chk(pre_bad == 0 && pre_n > 0, "R4", "launch-edge mismatches", pre_bad, 0);
    chk(ratio_err == !okv, "R7", "ratio_err", int'(ratio_err), int'(!okv));
    if (m) begin
      chk(mon_ratio == 64, "R3", "bit clocks per frame", mon_ratio, 64);
      chk(mon_per == 2 * BCK_HALF, "R3", "bit clock period", mon_per, 2 * BCK_HALF);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nh, w;
    logic [1:0] sp;
    logic dw, rx;
    void'($urandom(32'd1957));
    rst_n = 1'b0; chan_rst = 1'b1; master_en = 1'b0; rate_extreme = 1'b0;
    speed = 2'b00; wsel = 1'b0; bick_d = 1'b0; lrck_d = 1'b0;
    s1 = '0; s2 = '0; s3 = '0; s4 = '0;
    e_nh = 32; e_w = 24; e_ok = 1'b0; e_rise = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo_a == 0 && sdo_b == 0, "R9", "outputs in hold", int'({sdo_a, sdo_b}), 0);
    chk(ratio_err == 0, "R9", "ratio_err in hold", int'(ratio_err), 0);
    chk(bick_out == 0 && lrck_out == 0, "R9", "clocks in hold", int'({bick_out, lrck_out}), 0);

    run_cfg(0, 0, 2'b00, 1, 32, 32, 1, 0, "R1 R2 R5 32-bit at 64fs");
    run_cfg(0, 0, 2'b10, 0, 64, 24, 1, 0, "R1 R2 R5 24-bit at 128fs");
    run_cfg(0, 0, 2'b01, 0, 24, 24, 1, 0, "R2 R5 24-bit at 48fs");
    run_cfg(0, 0, 2'b11, 1, 16, 16, 1, 0, "R2 R6 forced 16-bit at 32fs");
    run_cfg(0, 0, 2'b11, 1, 24, 24, 1, 0, "R2 R6 forced 24-bit at 48fs");
    run_cfg(0, 0, 2'b11, 0, 32, 24, 1, 0, "R6 24-bit at 64fs");
    run_cfg(0, 1, 2'b11, 1, 32, 32, 1, 0, "R4 R6 rising launch");
    run_cfg(0, 1, 2'b00, 0, 40, 24, 1, 0, "R4 rising launch normal");
    run_cfg(0, 0, 2'b00, 0, 20, 24, 0, 0, "R7 ratio 40 muted");
    run_cfg(0, 0, 2'b00, 1, 68, 32, 0, 0, "R7 ratio 136 muted");
    run_cfg(0, 0, 2'b11, 0, 28, 24, 0, 0, "R7 oct ratio 56 muted");
    run_cfg(0, 0, 2'b11, 0, 16, 16, 1, 1, "R8 late change ignored");
    run_cfg(1, 1, 2'b00, 1, 32, 32, 1, 0, "R1 R2 R3 master 32-bit");
    run_cfg(1, 0, 2'b11, 0, 32, 24, 1, 0, "R3 R6 master oct 24-bit");

    @(negedge clk); chan_rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bick_out == 0 && lrck_out == 0 && sdo_a == 0 && sdo_b == 0, "R9",
        "quiet after master hold", int'({bick_out, lrck_out, sdo_a, sdo_b}), 0);

    for (int i = 0; i < 8; i++) begin
      sp = 2'($urandom % 4); dw = 1'($urandom % 2); rx = 1'($urandom % 2);
      if (sp == 2'b11) begin
        case ($urandom % 3)
          0: begin nh = 16; w = 16; end
          1: begin nh = 24; w = 24; end
          default: begin nh = 32; w = dw ? 32 : 24; end
        endcase
      end else begin
        w = dw ? 32 : 24;
        nh = w + int'($urandom % (65 - w));
      end
      run_cfg(0, rx, sp, dw, nh, w, 1, 0, "R1 R2 R5 R6 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule